// File: doc/BRIEF.md
# Paged management-to-32-bit register bridge

This block sits behind a 16-bit serial management slave and opens a 32-bit internal register space to it. The serial front end is modelled here as a parallel access strobe that carries a PHY address, a register number, a direction and 16 bits of write data. One fixed management location holds a page value. The page value supplies the upper part of the internal address. The PHY addresses in a window of eight, together with the register number, supply the lower part of the address and choose which half of the 32-bit word is accessed.

Each internal word is split across an even and an odd register number. The even register holds bits 15:0 and the odd register holds bits 31:16. Software reads the low half first and then the high half. It writes the high half first and then the low half. The bridge turns each such pair into one atomic 32-bit access on a simple request/acknowledge register bus, which has no byte enables and uses word-aligned byte addresses. A high-half write is only staged. The internal write happens when the low half arrives. A low-half read fetches the whole word and keeps its upper half, so the high-half read that follows comes from the same snapshot.

Top module: `mgmt_page_bridge`

## Requirements
- R1: The page register sits at PHY address 0x1F, register 0x10. It resets to zero and keeps write-data bits 8:0. A read of it returns those 9 bits, zero-extended to 16 bits.
- R2: The window covers PHY addresses 0x10 to 0x17. Inside it, the internal byte address is {page[8:0], phy[2:0], reg[4:1], 2'b00}. This makes an 18-bit byte address whose two low bits are always zero.
- R3: A write to an odd register in the window stages its 16 bits and is acknowledged. It starts no bus cycle.
- R4: A write to an even register in the window starts exactly one bus write. Its data is {most recently staged high half, write data}. A staged value stays in use until the next odd-register write replaces it.
- R5: A read of an even register in the window starts exactly one bus read. It returns bus bits 15:0 and keeps bus bits 31:16 as the snapshot.
- R6: A read of an odd register in the window returns the snapshot from the last even-register read. It starts no bus cycle, even if the word has been rewritten since.
- R7: An access to any other PHY address, or to PHY 0x1F at any register other than 0x10, causes no bus cycle and changes no state. A write is acknowledged, and a read returns 0xFFFF.
- R8: A bus request holds its address, direction and data steady until the acknowledge. A management strobe that arrives while a bus cycle is in progress is ignored.
- R9: Every accepted management access gets exactly one acknowledge, one cycle wide. Read data is valid while the acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_req | input | 1 | One-cycle management access strobe |
| mgmt_we | input | 1 | 1 = write, 0 = read |
| mgmt_phy | input | 5 | Management PHY address |
| mgmt_reg | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_ack | output | 1 | One-cycle completion pulse |
| mgmt_rdata | output | 16 | Read data, valid with mgmt_ack |
| bus_req | output | 1 | Internal bus request, held until bus_ack |
| bus_we | output | 1 | Internal bus write enable |
| bus_addr | output | 18 | Internal byte address, word aligned |
| bus_wdata | output | 32 | Internal bus write data |
| bus_ack | input | 1 | Internal bus acknowledge |
| bus_rdata | input | 32 | Internal bus read data, valid with bus_ack |

## Verification
The bench checks the following corner cases, and what a wrong design would do in each:
- **Snapshot after a rewrite.** The bench reads the low half of a word, rewrites the whole word, then reads the high half. A bridge that fetched again, or did not keep the snapshot, would return the new upper bits instead of the old ones.
- **Stale staging.** It issues a low-half write with no fresh high-half write before it. A bridge that cleared or ignored its staging register would put the wrong upper half on the bus.
- **Address limits.** It runs page 0x1FF with PHY 0x17 and register 0x1E, and it probes addresses just outside the window. A bridge with a wrong bit split or a loose window decode would send the wrong bus address or start a bus cycle it should not.
- **Strobe during a bus cycle.** It sends a page write while a slow bus read is still open. A bridge that accepted it would change the page or send an extra acknowledge.

// File: rtl/mgmt_page_bridge_pkg.sv
package mgmt_page_bridge_pkg;

   // decoded kind of one management access
   typedef enum logic [2:0] {
      OP_PAGE_WR,
      OP_PAGE_RD,
      OP_HI_WR,
      OP_HI_RD,
      OP_LO_WR,
      OP_LO_RD,
      OP_DROP,
      OP_FILL
   } op_e;

   typedef enum logic {
      ST_IDLE,
      ST_BUS
   } st_e;

endpackage

// File: rtl/mgmt_page_bridge_decode.sv
module mgmt_page_bridge_decode
   import mgmt_page_bridge_pkg::*;
#(
   parameter int PHY_W        = 5,
   parameter int REG_W        = 5,
   parameter int WIN_PHY_BITS = 3,
   parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
   parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
   parameter logic [PHY_W-1:0] WIN_BASE = 5'h10,
   parameter int IDX_W        = WIN_PHY_BITS + REG_W - 1
) (
   input  logic             we,
   input  logic [PHY_W-1:0] phy,
   input  logic [REG_W-1:0] rg,
   output op_e              op,
   output logic [IDX_W-1:0] idx
);

   logic is_page;
   logic in_win;

   assign is_page = (phy == PAGE_PHY) && (rg == PAGE_REG);
   assign in_win  = (phy >> WIN_PHY_BITS) == (WIN_BASE >> WIN_PHY_BITS);

   always_comb begin
      if (is_page)
         op = we ? OP_PAGE_WR : OP_PAGE_RD;
      else if (in_win && rg[0])
         op = we ? OP_HI_WR : OP_HI_RD;
      else if (in_win)
         op = we ? OP_LO_WR : OP_LO_RD;
      else
         op = we ? OP_DROP : OP_FILL;
   end

   // word index inside a page: window PHY bits above the register pair number
   generate
      if (WIN_PHY_BITS > 0) begin : g_multi_phy
         assign idx = {phy[WIN_PHY_BITS-1:0], rg[REG_W-1:1]};
      end else begin : g_single_phy
         assign idx = rg[REG_W-1:1];
      end
   endgenerate

endmodule

// File: rtl/mgmt_page_bridge_regs.sv
module mgmt_page_bridge_regs #(
   parameter int DATA_W = 16,
   parameter int PAGE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              page_load,
   input  logic              stage_load,
   input  logic              snap_load,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] snap_in,
   output logic [PAGE_W-1:0] page,
   output logic [DATA_W-1:0] stage_hi,
   output logic [DATA_W-1:0] snap_hi
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page     <= '0;
         stage_hi <= '0;
         snap_hi  <= '0;
      end else begin
         if (page_load)  page     <= wdata[PAGE_W-1:0];
         if (stage_load) stage_hi <= wdata;
         if (snap_load)  snap_hi  <= snap_in;
      end
   end

endmodule

// File: rtl/mgmt_page_bridge_seq.sv
module mgmt_page_bridge_seq
   import mgmt_page_bridge_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int PAGE_W = 9,
   parameter int IDX_W  = 7,
   parameter int BA_W   = PAGE_W + IDX_W + 2,
   parameter logic [DATA_W-1:0] FILL_VALUE = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  op_e                 op,
   input  logic [PAGE_W-1:0]   page,
   input  logic [IDX_W-1:0]    idx,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W-1:0]   stage_hi,
   input  logic [DATA_W-1:0]   snap_hi,
   output logic                page_load,
   output logic                stage_load,
   output logic                snap_load,
   output logic                ack,
   output logic [DATA_W-1:0]   rdata,
   output logic                bus_req,
   output logic                bus_we,
   output logic [BA_W-1:0]     bus_addr,
   output logic [2*DATA_W-1:0] bus_wdata,
   input  logic                bus_ack,
   input  logic [2*DATA_W-1:0] bus_rdata
);

   localparam int PAD_W = DATA_W - PAGE_W;

   st_e  state;
   logic take;

   assign take       = (state == ST_IDLE) && req;
   assign page_load  = take && (op == OP_PAGE_WR);
   assign stage_load = take && (op == OP_HI_WR);
   assign snap_load  = (state == ST_BUS) && bus_ack && !bus_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ack       <= 1'b0;
         rdata     <= '0;
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
      end else begin
         ack <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req) begin
                  case (op)
                     OP_PAGE_RD: begin
                        ack   <= 1'b1;
                        rdata <= {{PAD_W{1'b0}}, page};
                     end
                     OP_HI_RD: begin
                        ack   <= 1'b1;
                        rdata <= snap_hi;
                     end
                     OP_FILL: begin
                        ack   <= 1'b1;
                        rdata <= FILL_VALUE;
                     end
                     OP_LO_WR, OP_LO_RD: begin
                        bus_req   <= 1'b1;
                        bus_we    <= (op == OP_LO_WR);
                        bus_addr  <= {page, idx, 2'b00};
                        bus_wdata <= (op == OP_LO_WR) ? {stage_hi, wdata} : '0;
                        state     <= ST_BUS;
                     end
                     default: begin
                        ack   <= 1'b1;
                        rdata <= '0;
                     end
                  endcase
               end
            end
            ST_BUS: begin
               if (bus_ack) begin
                  bus_req <= 1'b0;
                  ack     <= 1'b1;
                  rdata   <= bus_we ? '0 : bus_rdata[DATA_W-1:0];
                  state   <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mgmt_page_bridge.sv
module mgmt_page_bridge
   import mgmt_page_bridge_pkg::*;
#(
   parameter int PHY_W        = 5,
   parameter int REG_W        = 5,
   parameter int DATA_W       = 16,
   parameter int PAGE_W       = 9,
   parameter int WIN_PHY_BITS = 3,
   parameter logic [PHY_W-1:0]  PAGE_PHY   = 5'h1F,
   parameter logic [REG_W-1:0]  PAGE_REG   = 5'h10,
   parameter logic [PHY_W-1:0]  WIN_BASE   = 5'h10,
   parameter logic [DATA_W-1:0] FILL_VALUE = '1,
   localparam int IDX_W = WIN_PHY_BITS + REG_W - 1,
   localparam int BA_W  = PAGE_W + IDX_W + 2,
   localparam int BUS_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mgmt_req,
   input  logic              mgmt_we,
   input  logic [PHY_W-1:0]  mgmt_phy,
   input  logic [REG_W-1:0]  mgmt_reg,
   input  logic [DATA_W-1:0] mgmt_wdata,
   output logic              mgmt_ack,
   output logic [DATA_W-1:0] mgmt_rdata,
   output logic              bus_req,
   output logic              bus_we,
   output logic [BA_W-1:0]   bus_addr,
   output logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_ack,
   input  logic [BUS_W-1:0]  bus_rdata
);

   // elaboration-time parameter checks
   generate
      if (PAGE_W < 1 || PAGE_W >= DATA_W) begin : g_bad_page
         $error("page width must be between 1 and DATA_W-1");
      end
      if (REG_W < 2) begin : g_bad_reg
         $error("register number needs at least two bits");
      end
      if (WIN_PHY_BITS >= PHY_W) begin : g_bad_win
         $error("window must leave PHY address bits for decoding");
      end
      if ((WIN_BASE % (1 << WIN_PHY_BITS)) != 0) begin : g_bad_base
         $error("window base must be aligned to the window size");
      end
      if ((PAGE_PHY >> WIN_PHY_BITS) == (WIN_BASE >> WIN_PHY_BITS)) begin : g_bad_overlap
         $error("page register location falls inside the window");
      end
   endgenerate

   op_e               op;
   logic [IDX_W-1:0]  idx;
   logic [PAGE_W-1:0] page;
   logic [DATA_W-1:0] stage_hi;
   logic [DATA_W-1:0] snap_hi;
   logic              page_load;
   logic              stage_load;
   logic              snap_load;

   mgmt_page_bridge_decode #(
      .PHY_W        (PHY_W),
      .REG_W        (REG_W),
      .WIN_PHY_BITS (WIN_PHY_BITS),
      .PAGE_PHY     (PAGE_PHY),
      .PAGE_REG     (PAGE_REG),
      .WIN_BASE     (WIN_BASE),
      .IDX_W        (IDX_W)
   ) u_decode (
      .we  (mgmt_we),
      .phy (mgmt_phy),
      .rg  (mgmt_reg),
      .op  (op),
      .idx (idx)
   );

   mgmt_page_bridge_regs #(
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .page_load  (page_load),
      .stage_load (stage_load),
      .snap_load  (snap_load),
      .wdata      (mgmt_wdata),
      .snap_in    (bus_rdata[BUS_W-1:DATA_W]),
      .page       (page),
      .stage_hi   (stage_hi),
      .snap_hi    (snap_hi)
   );

   mgmt_page_bridge_seq #(
      .DATA_W     (DATA_W),
      .PAGE_W     (PAGE_W),
      .IDX_W      (IDX_W),
      .BA_W       (BA_W),
      .FILL_VALUE (FILL_VALUE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (mgmt_req),
      .op         (op),
      .page       (page),
      .idx        (idx),
      .wdata      (mgmt_wdata),
      .stage_hi   (stage_hi),
      .snap_hi    (snap_hi),
      .page_load  (page_load),
      .stage_load (stage_load),
      .snap_load  (snap_load),
      .ack        (mgmt_ack),
      .rdata      (mgmt_rdata),
      .bus_req    (bus_req),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_ack    (bus_ack),
      .bus_rdata  (bus_rdata)
   );

endmodule

// File: rtl/mgmt_page_bridge_chk.sv
module mgmt_page_bridge_chk #(
   parameter int PHY_W        = 5,
   parameter int REG_W        = 5,
   parameter int DATA_W       = 16,
   parameter int WIN_PHY_BITS = 3,
   parameter logic [PHY_W-1:0] WIN_BASE = 5'h10,
   parameter int BA_W         = 18
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mgmt_req,
   input logic [PHY_W-1:0]    mgmt_phy,
   input logic [REG_W-1:0]    mgmt_reg,
   input logic [DATA_W-1:0]   mgmt_wdata,
   input logic                mgmt_ack,
   input logic [DATA_W-1:0]   mgmt_rdata,
   input logic                bus_req,
   input logic                bus_we,
   input logic [BA_W-1:0]     bus_addr,
   input logic [2*DATA_W-1:0] bus_wdata,
   input logic                bus_ack,
   input logic [2*DATA_W-1:0] bus_rdata
);

   assert_bus_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

   assert_bus_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> !bus_req && mgmt_ack);

   assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_ack |=> !mgmt_ack);

   assert_addr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> bus_addr[1:0] == 2'b00);

   assert_window_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(mgmt_req) &&
         (($past(mgmt_phy) >> WIN_PHY_BITS) == (WIN_BASE >> WIN_PHY_BITS)));

   assert_even_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> !$past(mgmt_reg[0]));

   assert_low_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) && bus_we |-> bus_wdata[DATA_W-1:0] == $past(mgmt_wdata));

   assert_read_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && !bus_we |=> mgmt_rdata == $past(bus_rdata[DATA_W-1:0]));

endmodule

bind mgmt_page_bridge mgmt_page_bridge_chk #(
   .PHY_W        (PHY_W),
   .REG_W        (REG_W),
   .DATA_W       (DATA_W),
   .WIN_PHY_BITS (WIN_PHY_BITS),
   .WIN_BASE     (WIN_BASE),
   .BA_W         (BA_W)
) u_chk (.*);

// File: tb/mgmt_page_bridge_bench.sv
module mgmt_page_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mgmt_req = 1'b0;
   logic        mgmt_we = 1'b0;
   logic [4:0]  mgmt_phy = '0;
   logic [4:0]  mgmt_reg = '0;
   logic [15:0] mgmt_wdata = '0;
   logic        mgmt_ack;
   logic [15:0] mgmt_rdata;
   logic        bus_req;
   logic        bus_we;
   logic [17:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   always #4 clk = ~clk;   // 125 MHz

   mgmt_page_bridge u_mgmt_page_bridge (
      .clk(clk), .rst_n(rst_n), .mgmt_req(mgmt_req), .mgmt_we(mgmt_we),
      .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata),
      .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata), .bus_req(bus_req),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int cnt = 0;
   int bus_count = 0;

   typedef struct { logic chk; logic [15:0] val; int rq; } rsp_t;
   typedef struct { logic we; logic [17:0] addr; logic [31:0] data; int rq; } bus_t;
   rsp_t rsp_q[$];
   bus_t bus_q[$];
   logic [31:0] mem [logic [17:0]];

   function automatic logic [31:0] dflt(logic [17:0] a);
      return {~a[17:2], a[17:2]};
   endfunction

   function automatic logic [31:0] peek(logic [17:0] a);
      return mem.exists(a) ? mem[a] : dflt(a);
   endfunction

   function automatic logic [17:0] baddr(logic [8:0] pg, logic [4:0] phy, logic [4:0] rg);
      return {pg, phy[2:0], rg[4:1], 2'b00};
   endfunction

   task automatic check(int rq, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
      end
   endtask

   // internal register model with programmable latency
   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ack = 1'b0;
         cnt = 0;
      end else if (bus_ack) begin
         bus_ack = 1'b0;
      end else if (bus_req) begin
         if (cnt < lat) cnt++;
         else begin
            bus_t e;
            cnt = 0;
            bus_ack = 1'b1;
            bus_count++;
            if (bus_q.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R7 unexpected bus access: got addr %h expected none", bus_addr);
            end else begin
               e = bus_q.pop_front();
               check(e.rq, "bus direction", {31'd0, bus_we}, {31'd0, e.we});
               check(e.rq, "bus address", {14'd0, bus_addr}, {14'd0, e.addr});
               if (e.we) check(e.rq, "bus write data", bus_wdata, e.data);
            end
            if (bus_we) mem[bus_addr] = bus_wdata;
            else bus_rdata = peek(bus_addr);
         end
      end
   end

   // response monitor (scoreboard side)
   always @(negedge clk) begin
      if (rst_n && mgmt_ack) begin
         if (rsp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R9 unexpected acknowledge: got 1 expected 0");
         end else begin
            rsp_t r;
            r = rsp_q.pop_front();
            if (r.chk) check(r.rq, "read data", {16'd0, mgmt_rdata}, {16'd0, r.val});
         end
      end
   end

   task automatic access(logic we, logic [4:0] phy, logic [4:0] rg, logic [15:0] wd,
                         logic chk, logic [15:0] exp, int rq);
      rsp_t r;
      r.chk = chk; r.val = exp; r.rq = rq;
      rsp_q.push_back(r);
      @(negedge clk);
      mgmt_req = 1'b1; mgmt_we = we; mgmt_phy = phy; mgmt_reg = rg; mgmt_wdata = wd;
      @(negedge clk);
      mgmt_req = 1'b0;
      while (!mgmt_ack) @(negedge clk);
   endtask

   task automatic wr(logic [4:0] phy, logic [4:0] rg, logic [15:0] wd, int rq);
      access(1'b1, phy, rg, wd, 1'b0, 16'h0, rq);
   endtask

   task automatic rd(logic [4:0] phy, logic [4:0] rg, logic [15:0] exp, int rq);
      access(1'b0, phy, rg, 16'h0, 1'b1, exp, rq);
   endtask

   task automatic expect_bus(logic we, logic [17:0] a, logic [31:0] d, int rq);
      bus_t e;
      e.we = we; e.addr = a; e.data = d; e.rq = rq;
      bus_q.push_back(e);
   endtask

   initial begin
      logic [17:0] a1;
      logic [17:0] a2;
      logic [31:0] d2;
      int n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state (R9, R8)
      check(9, "ack after reset", {31'd0, mgmt_ack}, 32'd0);
      check(8, "bus_req after reset", {31'd0, bus_req}, 32'd0);

      // R1: page register reset value, 9-bit keep, read back
      rd(5'h1F, 5'h10, 16'h0000, 1);
      wr(5'h1F, 5'h10, 16'hFFFF, 1);
      rd(5'h1F, 5'h10, 16'h01FF, 1);
      wr(5'h1F, 5'h10, 16'h0005, 1);
      rd(5'h1F, 5'h10, 16'h0005, 1);

      // R3: high-half write only stages
      n0 = bus_count;
      wr(5'h13, 5'h07, 16'hBEEF, 3);
      check(3, "bus cycles after high write", bus_count, n0);

      // R4 / R2: low-half write commits {staged, low} at the paged address
      a1 = baddr(9'h005, 5'h13, 5'h06);
      expect_bus(1'b1, a1, 32'hBEEF1234, 4);
      wr(5'h13, 5'h06, 16'h1234, 4);
      check(2, "model word after commit", peek(a1), 32'hBEEF1234);

      // R5 / R6: read low fetches, read high uses snapshot
      expect_bus(1'b0, a1, 32'h0, 5);
      rd(5'h13, 5'h06, 16'h1234, 5);
      n0 = bus_count;
      rd(5'h13, 5'h07, 16'hBEEF, 6);
      check(6, "bus cycles after high read", bus_count, n0);

      // R6: snapshot survives a full rewrite of the word
      a2 = baddr(9'h005, 5'h10, 5'h00);
      d2 = dflt(a2);
      lat = 2;
      expect_bus(1'b0, a2, 32'h0, 5);
      rd(5'h10, 5'h00, d2[15:0], 5);
      wr(5'h10, 5'h01, 16'hAAAA, 3);
      expect_bus(1'b1, a2, 32'hAAAA5555, 4);
      wr(5'h10, 5'h00, 16'h5555, 4);
      rd(5'h10, 5'h01, d2[31:16], 6);

      // R4: low write with no fresh high half reuses the staged one
      expect_bus(1'b1, baddr(9'h005, 5'h17, 5'h1E), 32'hAAAA0001, 4);
      wr(5'h17, 5'h1E, 16'h0001, 4);

      // R7: outside the window and the page location
      n0 = bus_count;
      wr(5'h05, 5'h00, 16'h1111, 7);
      wr(5'h18, 5'h02, 16'h2222, 7);
      wr(5'h1F, 5'h11, 16'h0077, 7);
      rd(5'h05, 5'h00, 16'hFFFF, 7);
      rd(5'h18, 5'h00, 16'hFFFF, 7);
      rd(5'h0F, 5'h06, 16'hFFFF, 7);
      rd(5'h1F, 5'h11, 16'hFFFF, 7);
      check(7, "bus cycles for ignored accesses", bus_count, n0);
      rd(5'h1F, 5'h10, 16'h0005, 7);
      expect_bus(1'b0, a1, 32'h0, 7);
      rd(5'h13, 5'h06, 16'h1234, 7);
      rd(5'h13, 5'h07, 16'hBEEF, 7);

      // R2: top corner of the address space
      lat = 0;
      wr(5'h1F, 5'h10, 16'h01FF, 1);
      wr(5'h17, 5'h1F, 16'hCAFE, 3);
      expect_bus(1'b1, 18'h3FFFC, 32'hCAFEBABE, 2);
      wr(5'h17, 5'h1E, 16'hBABE, 2);
      lat = 3;
      expect_bus(1'b0, 18'h3FFFC, 32'h0, 5);
      rd(5'h17, 5'h1E, 16'hBABE, 5);
      rd(5'h17, 5'h1F, 16'hCAFE, 6);

      // R8: strobe during an open bus cycle is ignored
      lat = 6;
      a2 = baddr(9'h1FF, 5'h10, 5'h02);
      d2 = dflt(a2);
      expect_bus(1'b0, a2, 32'h0, 8);
      begin
         rsp_t r;
         r.chk = 1'b1; r.val = d2[15:0]; r.rq = 8;
         rsp_q.push_back(r);
      end
      @(negedge clk);
      mgmt_req = 1'b1; mgmt_we = 1'b0; mgmt_phy = 5'h10; mgmt_reg = 5'h02;
      @(negedge clk);
      mgmt_req = 1'b0;
      @(negedge clk);
      mgmt_req = 1'b1; mgmt_we = 1'b1; mgmt_phy = 5'h1F; mgmt_reg = 5'h10; mgmt_wdata = 16'h0033;
      @(negedge clk);
      mgmt_req = 1'b0;
      while (!mgmt_ack) @(negedge clk);
      repeat (4) @(negedge clk);
      lat = 0;
      rd(5'h1F, 5'h10, 16'h01FF, 8);

      repeat (5) @(negedge clk);
      check(9, "responses outstanding", rsp_q.size(), 0);
      check(8, "bus cycles outstanding", bus_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired: got no completion expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule